// File: doc/BRIEF.md
# SPI Streaming Register-Access Slave

This block is an SPI slave that lets a master read and write a small bank of byte-wide registers: two manufacturer ID bytes, a product ID byte, and a set of clock-generator control fields. The control fields are enable, bypass, a 26-bit trim word, a 3-bit source select and a 5-bit divider. The block only holds the control values on its output ports. Whatever logic consumes them lies outside it.

A transaction opens when the active-low chip select goes low. The first byte names the operation and the second byte sets the starting register address. After that, every further byte moves one register, and the address advances by one after each byte. The stream runs until chip select rises. The SPI pins are sampled by the system clock through a synchronizer, so SCK must stay well below the system clock rate.

The controller is a state machine with these states:
- `ST_IDLE`: chip select is high.
- `ST_CMD`: the command byte is being received.
- `ST_ADDR_RD` and `ST_ADDR_WR`: the address byte is being received for a read or a write.
- `ST_READ` and `ST_WRITE`: the data stream is running.
- `ST_IGNORE`: the command was not recognised.

The transitions are:
- `ST_IDLE`→`ST_CMD` when chip select goes low.
- `ST_CMD`→`ST_ADDR_RD` on command 0x40.
- `ST_CMD`→`ST_ADDR_WR` on command 0x80.
- `ST_CMD`→`ST_IGNORE` on any other command.
- `ST_ADDR_RD`→`ST_READ` and `ST_ADDR_WR`→`ST_WRITE` when the address byte completes.
- Any state → `ST_IDLE` whenever chip select is high.

Top module: `spi_regacc_slave`

## Requirements
- R1: After reset, `spi_miso` is 0 and every control output holds its reset parameter value.
- R2: The slave uses SPI mode 0 with MSB first. It takes MOSI on the rising SCK edge and changes MISO after the falling edge. Command byte 0x40 followed by an address byte A returns the register at A on the third byte.
- R3: Each additional byte in a stream moves the register at the next address, which is one above the previous address.
- R4: Address 0x01 reads the high manufacturer ID byte, 0x02 reads the low manufacturer ID byte, and 0x03 reads the product ID.
- R5: Command 0x80 writes each data byte to the current address and then advances the address. The writable registers are:
  - 0x08: enable (8 bits).
  - 0x09: bypass (8 bits).
  - 0x0d to 0x10: trim bits 25:24 (in the byte's bits 1:0), then 23:16, 15:8 and 7:0.
  - 0x11: select (bits 2:0).
  - 0x12: divider (bits 4:0).

  Reading a register returns its unused upper bits as 0.
- R6: Writes to the ID addresses or to unmapped addresses change nothing.
- R7: Reads from unmapped addresses return 0x00.
- R8: The address counter wraps from 0xFF to 0x00.
- R9: After any command byte other than 0x40 or 0x80, the remaining bytes change no register, and MISO stays 0 until chip select rises.
- R10: Raising chip select ends the stream and discards a partial byte. The next transaction must begin again with a command byte.
- R11: MISO is 0 while the command and address bytes are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Active-low chip select |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Master-to-slave data |
| spi_miso | output | 1 | Slave-to-master data |
| cfg_pll_en | output | 8 | Enable register |
| cfg_pll_bypass | output | 8 | Bypass register |
| cfg_pll_trim | output | 26 | Trim word |
| cfg_pll_sel | output | 3 | Source select |
| cfg_pll_div | output | 5 | Divider |

## Verification
The bench builds the slave with three synchronizer stages, which is one more than the default. It also uses ID values and control reset values that differ from the defaults, so that readback of the ID and reset values shows the parameters actually reach the read multiplexer. With a half SCK period of eight system clocks, the extra stage still leaves margin between MISO settling and the master's sampling point. This lets the bench check the timing of the first bit of each data byte. Starting a read at 0xFF brings the address wrap and the unmapped reads within reach in a single stream.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR_RD,
        ST_ADDR_WR,
        ST_READ,
        ST_WRITE,
        ST_IGNORE
    } xfer_state_e;

    localparam int          BYTE_W        = 8;
    localparam logic [7:0]  CMD_RD_STREAM = 8'h40;
    localparam logic [7:0]  CMD_WR_STREAM = 8'h80;

    localparam logic [7:0]  A_MFG_HI  = 8'h01;
    localparam logic [7:0]  A_MFG_LO  = 8'h02;
    localparam logic [7:0]  A_PROD    = 8'h03;
    localparam logic [7:0]  A_EN      = 8'h08;
    localparam logic [7:0]  A_BYPASS  = 8'h09;
    localparam logic [7:0]  A_TRIM3   = 8'h0d;
    localparam logic [7:0]  A_TRIM2   = 8'h0e;
    localparam logic [7:0]  A_TRIM1   = 8'h0f;
    localparam logic [7:0]  A_TRIM0   = 8'h10;
    localparam logic [7:0]  A_SEL     = 8'h11;
    localparam logic [7:0]  A_DIV     = 8'h12;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn_in,
    input  logic sck_in,
    input  logic mosi_in,
    output logic csn_s,
    output logic mosi_s,
    output logic sck_rise,
    output logic sck_fall
);
    localparam int               NPIN    = 3;
    localparam logic [NPIN-1:0]  PIN_RST = 3'b100;   // csn idles high

    logic [NPIN-1:0] pin_in;
    logic [NPIN-1:0] pin_s;
    logic            sck_prev;

    assign pin_in = {csn_in, sck_in, mosi_in};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [STAGES-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {STAGES{PIN_RST[g]}};
            else        q <= {q[STAGES-2:0], pin_in[g]};
        end
        assign pin_s[g] = q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= pin_s[1];
    end

    assign csn_s    = pin_s[2];
    assign mosi_s   = pin_s[0];
    assign sck_rise =  pin_s[1] & ~sck_prev;
    assign sck_fall = ~pin_s[1] &  sck_prev;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
        end else begin
            if (sck_rise) begin
                rx_q    <= {rx_q[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (sck_fall) begin
                // falling edge after the last bit of a byte presents the next byte's MSB
                if (bit_cnt == '0) tx_q <= load_byte;
                else               tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign byte_valid = sck_rise && (bit_cnt == LAST_BIT);
    assign rx_byte    = {rx_q[BYTE_W-2:0], mosi_s};
    assign miso       = tx_q[BYTE_W-1];
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_regacc_pkg::*;
#(
    parameter logic [15:0] MFG_ID      = 16'h0456,
    parameter logic [7:0]  PROD_ID     = 8'h11,
    parameter logic [7:0]  EN_RST      = 8'h00,
    parameter logic [7:0]  BYPASS_RST  = 8'h01,
    parameter int          TRIM_W      = 26,
    parameter logic [TRIM_W-1:0] TRIM_RST = '0,
    parameter int          SEL_W       = 3,
    parameter logic [SEL_W-1:0]  SEL_RST  = '0,
    parameter int          DIV_W       = 5,
    parameter logic [DIV_W-1:0]  DIV_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [7:0]        en_q,
    output logic [7:0]        bypass_q,
    output logic [TRIM_W-1:0] trim_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DIV_W-1:0]  div_q
);
    localparam int TOP_W = TRIM_W - 3 * BYTE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= EN_RST;
            bypass_q <= BYPASS_RST;
            trim_q   <= TRIM_RST;
            sel_q    <= SEL_RST;
            div_q    <= DIV_RST;
        end else if (wr_en) begin
            case (addr)
                A_EN:     en_q     <= wr_data;
                A_BYPASS: bypass_q <= wr_data;
                A_TRIM3:  trim_q[TRIM_W-1 -: TOP_W] <= wr_data[TOP_W-1:0];
                A_TRIM2:  trim_q[23:16] <= wr_data;
                A_TRIM1:  trim_q[15:8]  <= wr_data;
                A_TRIM0:  trim_q[7:0]   <= wr_data;
                A_SEL:    sel_q    <= wr_data[SEL_W-1:0];
                A_DIV:    div_q    <= wr_data[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            A_MFG_HI: rd_data = MFG_ID[15:8];
            A_MFG_LO: rd_data = MFG_ID[7:0];
            A_PROD:   rd_data = PROD_ID;
            A_EN:     rd_data = en_q;
            A_BYPASS: rd_data = bypass_q;
            A_TRIM3:  rd_data[TOP_W-1:0] = trim_q[TRIM_W-1 -: TOP_W];
            A_TRIM2:  rd_data = trim_q[23:16];
            A_TRIM1:  rd_data = trim_q[15:8];
            A_TRIM0:  rd_data = trim_q[7:0];
            A_SEL:    rd_data[SEL_W-1:0] = sel_q;
            A_DIV:    rd_data[DIV_W-1:0] = div_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/spi_regacc_slave.sv
module spi_regacc_slave
    import spi_regacc_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] MFG_ID      = 16'h0456,
    parameter logic [7:0]  PROD_ID     = 8'h11,
    parameter logic [7:0]  EN_RST      = 8'h00,
    parameter logic [7:0]  BYPASS_RST  = 8'h01,
    parameter logic [25:0] TRIM_RST    = 26'h0000000,
    parameter logic [2:0]  SEL_RST     = 3'd0,
    parameter logic [4:0]  DIV_RST     = 5'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_csn,
    input  logic        spi_sck,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic [7:0]  cfg_pll_en,
    output logic [7:0]  cfg_pll_bypass,
    output logic [25:0] cfg_pll_trim,
    output logic [2:0]  cfg_pll_sel,
    output logic [4:0]  cfg_pll_div
);
    xfer_state_e       state_q, state_d;
    logic [7:0]        addr_q, addr_d;
    logic              csn_s, mosi_s, sck_rise, sck_fall;
    logic              byte_valid, wr_en;
    logic [BYTE_W-1:0] rx_byte, rd_data, load_byte;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .csn_in(spi_csn), .sck_in(spi_sck), .mosi_in(spi_mosi),
        .csn_s(csn_s), .mosi_s(mosi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    spi_byte_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .clear(csn_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .load_byte(load_byte), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .miso(spi_miso)
    );

    spi_cfg_regs #(
        .MFG_ID(MFG_ID), .PROD_ID(PROD_ID), .EN_RST(EN_RST), .BYPASS_RST(BYPASS_RST),
        .TRIM_W(26), .TRIM_RST(TRIM_RST), .SEL_W(3), .SEL_RST(SEL_RST),
        .DIV_W(5), .DIV_RST(DIV_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr_q),
        .wr_data(rx_byte), .rd_data(rd_data),
        .en_q(cfg_pll_en), .bypass_q(cfg_pll_bypass), .trim_q(cfg_pll_trim),
        .sel_q(cfg_pll_sel), .div_q(cfg_pll_div)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_CMD;
            ST_CMD:
                if (byte_valid) begin
                    if (rx_byte == CMD_RD_STREAM)      state_d = ST_ADDR_RD;
                    else if (rx_byte == CMD_WR_STREAM) state_d = ST_ADDR_WR;
                    else                               state_d = ST_IGNORE;
                end
            ST_ADDR_RD:
                if (byte_valid) begin
                    addr_d  = rx_byte;
                    state_d = ST_READ;
                end
            ST_ADDR_WR:
                if (byte_valid) begin
                    addr_d  = rx_byte;
                    state_d = ST_WRITE;
                end
            ST_READ, ST_WRITE:
                if (byte_valid) addr_d = addr_q + 8'd1;
            ST_IGNORE:  state_d = ST_IGNORE;
            default:    state_d = ST_IDLE;
        endcase
        if (csn_s) state_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        wr_en     = (state_q == ST_WRITE) && byte_valid && !csn_s;
        load_byte = (state_q == ST_READ) ? rd_data : '0;
    end
endmodule

// File: rtl/spi_regacc_checker.sv
module spi_regacc_checker
    import spi_regacc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input xfer_state_e state,
    input logic        csn_s,
    input logic        byte_valid,
    input logic        wr_en,
    input logic [7:0]  addr,
    input logic        miso
);
    p_quiet_hdr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD || state == ST_ADDR_RD || state == ST_ADDR_WR) |-> !miso)
        else $error("R11: MISO active during header");

    p_quiet_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !miso)
        else $error("R9: MISO active after unknown command or idle");

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_READ || state == ST_WRITE) && byte_valid && !csn_s)
            |=> (addr == $past(addr) + 8'd1))
        else $error("R3: address did not advance by one");

    p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_WRITE))
        else $error("R9: write outside write stream");

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (state == ST_IDLE))
        else $error("R10: stream survived chip select release");
endmodule

bind spi_regacc_slave spi_regacc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .csn_s(csn_s),
    .byte_valid(byte_valid), .wr_en(wr_en), .addr(addr_q), .miso(spi_miso)
);

// File: tb/tb_spi_regacc_slave.sv
module tb_spi_regacc_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;   // system clocks per SCK half period

    localparam logic [15:0] T_MFG    = 16'h5A3C;
    localparam logic [7:0]  T_PROD   = 8'hC7;
    localparam logic [7:0]  T_EN     = 8'h01;
    localparam logic [7:0]  T_BYP    = 8'h00;
    localparam logic [25:0] T_TRIM   = 26'h2ABCDEF;
    localparam logic [2:0]  T_SEL    = 3'd2;
    localparam logic [4:0]  T_DIV    = 5'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso;
    logic [7:0]  cfg_pll_en, cfg_pll_bypass;
    logic [25:0] cfg_pll_trim;
    logic [2:0]  cfg_pll_sel;
    logic [4:0]  cfg_pll_div;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regacc_slave #(
        .SYNC_STAGES(3), .MFG_ID(T_MFG), .PROD_ID(T_PROD), .EN_RST(T_EN),
        .BYPASS_RST(T_BYP), .TRIM_RST(T_TRIM), .SEL_RST(T_SEL), .DIV_RST(T_DIV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .cfg_pll_en(cfg_pll_en), .cfg_pll_bypass(cfg_pll_bypass),
        .cfg_pll_trim(cfg_pll_trim), .cfg_pll_sel(cfg_pll_sel), .cfg_pll_div(cfg_pll_div)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        spi_csn  = 1'b1;
        spi_mosi = 1'b0;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic t_reset();
        chk("R1 miso", {31'd0, spi_miso}, 32'd0);
        chk("R1 en", {24'd0, cfg_pll_en}, {24'd0, T_EN});
        chk("R1 bypass", {24'd0, cfg_pll_bypass}, {24'd0, T_BYP});
        chk("R1 trim", {6'd0, cfg_pll_trim}, {6'd0, T_TRIM});
        chk("R1 sel", {29'd0, cfg_pll_sel}, {29'd0, T_SEL});
        chk("R1 div", {27'd0, cfg_pll_div}, {27'd0, T_DIV});
    endtask

    task automatic t_read_ids();
        logic [7:0] r;
        cs_begin();
        xfer(8'h40, r); chk("R11 cmd miso", {24'd0, r}, 32'd0);
        xfer(8'h01, r); chk("R11 addr miso", {24'd0, r}, 32'd0);
        xfer(8'h00, r); chk("R2 R4 mfg hi", {24'd0, r}, {24'd0, T_MFG[15:8]});
        xfer(8'h00, r); chk("R3 R4 mfg lo", {24'd0, r}, {24'd0, T_MFG[7:0]});
        xfer(8'h00, r); chk("R3 R4 prod", {24'd0, r}, {24'd0, T_PROD});
        cs_end();
    endtask

    task automatic t_read_unmapped();
        logic [7:0] r;
        cs_begin();
        xfer(8'h40, r);
        xfer(8'h04, r);
        for (int a = 4; a < 8; a++) begin
            xfer(8'h00, r); chk("R7 unmapped", {24'd0, r}, 32'd0);
        end
        xfer(8'h00, r); chk("R3 en after gap", {24'd0, r}, {24'd0, T_EN});
        cs_end();
    endtask

    task automatic t_wrap();
        logic [7:0] r;
        cs_begin();
        xfer(8'h40, r);
        xfer(8'hFF, r);
        xfer(8'h00, r); chk("R8 addr ff", {24'd0, r}, 32'd0);
        xfer(8'h00, r); chk("R8 addr 00", {24'd0, r}, 32'd0);
        xfer(8'h00, r); chk("R8 addr 01", {24'd0, r}, {24'd0, T_MFG[15:8]});
        cs_end();
    endtask

    task automatic t_write();
        logic [7:0] r;
        logic [7:0] wr [11] = '{8'hA5, 8'h3C, 8'h00, 8'h00, 8'h00,
                                8'hFF, 8'h12, 8'h34, 8'h56, 8'hFF, 8'hFF};
        logic [7:0] rb [6]  = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h07, 8'h1F};
        cs_begin();
        xfer(8'h80, r);
        xfer(8'h08, r);
        for (int i = 0; i < 11; i++) xfer(wr[i], r);
        cs_end();
        chk("R5 en", {24'd0, cfg_pll_en}, 32'hA5);
        chk("R5 bypass", {24'd0, cfg_pll_bypass}, 32'h3C);
        chk("R5 trim", {6'd0, cfg_pll_trim}, 32'h3123456);
        chk("R5 sel", {29'd0, cfg_pll_sel}, 32'd7);
        chk("R5 div", {27'd0, cfg_pll_div}, 32'h1F);
        cs_begin();
        xfer(8'h40, r);
        xfer(8'h0d, r);
        for (int i = 0; i < 6; i++) begin
            xfer(8'h00, r); chk("R5 readback masked", {24'd0, r}, {24'd0, rb[i]});
        end
        cs_end();
    endtask

    task automatic t_write_ro();
        logic [7:0] r;
        cs_begin();
        xfer(8'h80, r);
        xfer(8'h01, r);
        for (int i = 0; i < 7; i++) xfer(8'h00, r);  // 0x01..0x07
        cs_end();
        chk("R6 en kept", {24'd0, cfg_pll_en}, 32'hA5);
        cs_begin();
        xfer(8'h40, r);
        xfer(8'h01, r);
        xfer(8'h00, r); chk("R6 mfg hi kept", {24'd0, r}, {24'd0, T_MFG[15:8]});
        xfer(8'h00, r); chk("R6 mfg lo kept", {24'd0, r}, {24'd0, T_MFG[7:0]});
        xfer(8'h00, r); chk("R6 prod kept", {24'd0, r}, {24'd0, T_PROD});
        xfer(8'h00, r); chk("R6 unmapped stays 0", {24'd0, r}, 32'd0);
        cs_end();
    endtask

    task automatic t_bad_cmd();
        logic [7:0] r;
        logic [7:0] acc;
        acc = '0;
        cs_begin();
        xfer(8'h13, r); acc |= r;
        xfer(8'h08, r); acc |= r;
        xfer(8'h00, r); acc |= r;
        xfer(8'h00, r); acc |= r;
        xfer(8'h00, r); acc |= r;
        cs_end();
        chk("R9 miso quiet", {24'd0, acc}, 32'd0);
        chk("R9 en kept", {24'd0, cfg_pll_en}, 32'hA5);
        chk("R9 bypass kept", {24'd0, cfg_pll_bypass}, 32'h3C);
    endtask

    task automatic t_cs_abort();
        logic [7:0] r;
        cs_begin();
        xfer(8'h80, r);
        xfer(8'h09, r);
        xfer_bits(8'hFF, 4, r);
        cs_end();
        chk("R10 partial byte dropped", {24'd0, cfg_pll_bypass}, 32'h3C);
        cs_begin();
        xfer(8'h40, r); chk("R10 fresh cmd miso", {24'd0, r}, 32'd0);
        xfer(8'h09, r);
        xfer(8'h00, r); chk("R10 new stream read", {24'd0, r}, 32'h3C);
        cs_end();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_read_ids();
        t_read_unmapped();
        t_wrap();
        t_write();
        t_write_ro();
        t_bad_cmd();
        t_cs_abort();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule